// File: doc/BRIEF.md
# Type-C Source Attach Detector

This block tracks the connection state of a USB Type-C port acting as a power source. Analog comparators sit outside it. For each CC pin and each current-advertisement level they report whether the pin voltage is below the sink-termination threshold and whether it is below the lower cable-termination threshold. The block uses the level selected by configuration to sort each pin into open, sink-terminated (Rd) or cable-terminated (Ra). It debounces that result and decides what is attached.

From the settled pair of classifications the block decides several things. It chooses between a plain sink, a powered cable with or without a sink behind it, a debug accessory and an audio accessory. It raises the VBUS enable and routes VCONN to the cable-terminated pin. It reports plug orientation. After an attach it watches only the pins that matter for removal. Attach and detach use separate debounce lengths, which are given in clock cycles on input ports.

Top module: `tcsrc_attach`

## Requirements
- R1: While `rst_n` is low, and after it is released, the port is unattached: `vbus_en`, `vconn1_en`, `vconn2_en`, `orient`, `dbg_acc` and `aud_acc` are all 0. An attach after reset takes the full attach debounce.
- R2: `adv_sel` picks the comparator bit index: 0 selects default USB, 1 selects 1.5 A and 2 selects 3 A. The value 3 behaves as 0. A pin whose selected `*_lo_ra` bit is 1 reads Ra. Otherwise it reads Rd if its selected `*_lo_rd` bit is 1, and otherwise it reads open.
- R3: A new pin classification must hold unchanged for `t_attach` cycles before it is accepted. The outputs change on the (`t_attach`+2)-th rising edge after the input change. Any change in between restarts the count.
- R4: Rd on exactly one pin with the other pin open enables VBUS with both VCONN enables off. `orient` is 0 for Rd on CC1 and 1 for Rd on CC2.
- R5: In the sink state only the Rd pin is watched. Changes on the other pin have no effect. The Rd pin reading open for `t_detach` cycles ends the attach on the (`t_detach`+2)-th rising edge.
- R6: Ra on one pin with the other pin open is a cable without a sink, and all enables stay off. The Ra pin reading open ends this state. A debounced Rd on the open pin, while the Ra pin still reads Ra, moves the port to the cable-plus-sink state.
- R7: Ra on one pin with Rd on the other enables VBUS and enables VCONN only on the Ra pin. `orient` follows the Rd pin. The Ra pin reading open has no effect; only the Rd pin is watched.
- R8: Rd on both pins sets `dbg_acc` with VBUS off. Either pin reading open for `t_detach` cycles clears it.
- R9: Ra on both pins sets `aud_acc` with VBUS off. Either pin reading open for `t_detach` cycles clears it.
- R10: On any detach, VBUS and both VCONN enables drop in the same cycle, and the orientation and accessory flags are cleared.
- R11: In the cable-only state, cable removal takes priority over sink arrival in the same cycle. VCONN is never raised toward a pin that reads open.
- R12: `orient` is 0 whenever no sink-attached state is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| adv_sel | input | 2 | Current advertisement selector |
| cc1_lo_rd | input | 3 | CC1 below sink threshold, one bit per level |
| cc1_lo_ra | input | 3 | CC1 below cable threshold, one bit per level |
| cc2_lo_rd | input | 3 | CC2 below sink threshold, one bit per level |
| cc2_lo_ra | input | 3 | CC2 below cable threshold, one bit per level |
| t_attach | input | CNT_W | Attach debounce length in cycles |
| t_detach | input | CNT_W | Detach debounce length in cycles |
| vbus_en | output | 1 | VBUS source enable |
| vconn1_en | output | 1 | VCONN enable on CC1 |
| vconn2_en | output | 1 | VCONN enable on CC2 |
| orient | output | 1 | Sink on CC2 when 1 |
| dbg_acc | output | 1 | Debug accessory attached |
| aud_acc | output | 1 | Audio accessory attached |

## Verification
In the cable-only state, the debounced removal of the cable and the debounced arrival of a sink can mature in the same cycle. The bench provokes this by setting both debounce lengths to 5 and, at one clock edge, turning the Ra pin open and the open pin Rd. It expects the port to pass through the unattached state with every enable low. One cycle later it expects a plain sink attach with VBUS on, the orientation toward CC2 and VCONN still off.

// File: rtl/tcsrc_pkg.sv
package tcsrc_pkg;
  localparam int NUM_LVL = 3;
  localparam int LVL_W   = 2;

  typedef enum logic [1:0] {
    TERM_OPEN = 2'd0,
    TERM_RD   = 2'd1,
    TERM_RA   = 2'd2
  } cc_term_e;

  typedef enum logic [2:0] {
    ST_UNATT   = 3'd0,
    ST_SNK     = 3'd1,
    ST_CBL     = 3'd2,
    ST_SNK_CBL = 3'd3,
    ST_DBG     = 3'd4,
    ST_AUD     = 3'd5
  } port_st_e;
endpackage

// File: rtl/tcsrc_pin_class.sv
module tcsrc_pin_class
  import tcsrc_pkg::*;
(
  input  logic [LVL_W-1:0]   adv_sel,
  input  logic [NUM_LVL-1:0] lo_rd,
  input  logic [NUM_LVL-1:0] lo_ra,
  output cc_term_e           term
);
  logic [LVL_W-1:0] idx;

  // selector code 3 falls back to the default level (R2)
  always_comb begin
    idx = (adv_sel >= LVL_W'(NUM_LVL)) ? '0 : adv_sel;
  end

  always_comb begin
    if (lo_ra[idx])      term = TERM_RA;
    else if (lo_rd[idx]) term = TERM_RD;
    else                 term = TERM_OPEN;
  end
endmodule

// File: rtl/tcsrc_pin_debounce.sv
module tcsrc_pin_debounce
  import tcsrc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cc_term_e         term_in,
  output cc_term_e         term_q,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  cc_term_e         term_n;
  logic [CNT_W-1:0] cnt_n;
  logic             cnt_en;

  always_comb begin
    term_n = term_q;
    cnt_n  = cnt_q;
    cnt_en = (cnt_q != CNT_MAX);
    if (term_in != term_q) begin
      term_n = term_in;
      cnt_n  = '0;
    end else if (cnt_en) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      term_q <= TERM_OPEN;
      cnt_q  <= '0;
    end else begin
      term_q <= term_n;
      cnt_q  <= cnt_n;
    end
  end

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && term_in == term_q) |=> (cnt_q == CNT_MAX)) // R3
    else $error("debounce counter left saturation");
endmodule

// File: rtl/tcsrc_attach.sv
module tcsrc_attach
  import tcsrc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       adv_sel,
  input  logic [2:0]       cc1_lo_rd,
  input  logic [2:0]       cc1_lo_ra,
  input  logic [2:0]       cc2_lo_rd,
  input  logic [2:0]       cc2_lo_ra,
  input  logic [CNT_W-1:0] t_attach,
  input  logic [CNT_W-1:0] t_detach,
  output logic             vbus_en,
  output logic             vconn1_en,
  output logic             vconn2_en,
  output logic             orient,
  output logic             dbg_acc,
  output logic             aud_acc
);
  localparam int NPIN = 2;

  logic [NUM_LVL-1:0] lo_rd [NPIN];
  logic [NUM_LVL-1:0] lo_ra [NPIN];
  cc_term_e           raw   [NPIN];
  cc_term_e           cls   [NPIN];
  logic [CNT_W-1:0]   cnt   [NPIN];
  logic [NPIN-1:0]    att_ok;
  logic [NPIN-1:0]    gone;

  assign lo_rd[0] = cc1_lo_rd;
  assign lo_ra[0] = cc1_lo_ra;
  assign lo_rd[1] = cc2_lo_rd;
  assign lo_ra[1] = cc2_lo_ra;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    tcsrc_pin_class u_cls (
      .adv_sel (adv_sel),
      .lo_rd   (lo_rd[p]),
      .lo_ra   (lo_ra[p]),
      .term    (raw[p])
    );
    tcsrc_pin_debounce #(.CNT_W(CNT_W)) u_dbn (
      .clk     (clk),
      .rst_n   (rst_n),
      .term_in (raw[p]),
      .term_q  (cls[p]),
      .cnt_q   (cnt[p])
    );
    assign att_ok[p] = (cnt[p] >= t_attach);
    assign gone[p]   = (cls[p] == TERM_OPEN) && (cnt[p] >= t_detach);
  end

  port_st_e st_q, st_n;
  logic     key_q, key_n;  // Rd pin in sink states, Ra pin in cable-only state

  always_comb begin
    st_n  = st_q;
    key_n = key_q;
    unique case (st_q)
      ST_UNATT: begin
        if (att_ok[0] && att_ok[1]) begin
          if (cls[0] == TERM_RD && cls[1] == TERM_OPEN) begin
            st_n = ST_SNK; key_n = 1'b0;
          end else if (cls[0] == TERM_OPEN && cls[1] == TERM_RD) begin
            st_n = ST_SNK; key_n = 1'b1;
          end else if (cls[0] == TERM_RA && cls[1] == TERM_OPEN) begin
            st_n = ST_CBL; key_n = 1'b0;
          end else if (cls[0] == TERM_OPEN && cls[1] == TERM_RA) begin
            st_n = ST_CBL; key_n = 1'b1;
          end else if (cls[0] == TERM_RA && cls[1] == TERM_RD) begin
            st_n = ST_SNK_CBL; key_n = 1'b1;
          end else if (cls[0] == TERM_RD && cls[1] == TERM_RA) begin
            st_n = ST_SNK_CBL; key_n = 1'b0;
          end else if (cls[0] == TERM_RD && cls[1] == TERM_RD) begin
            st_n = ST_DBG;
          end else if (cls[0] == TERM_RA && cls[1] == TERM_RA) begin
            st_n = ST_AUD;
          end
        end
      end
      ST_SNK, ST_SNK_CBL: begin
        if (gone[key_q]) st_n = ST_UNATT;
      end
      ST_CBL: begin
        // removal outranks arrival (R11)
        if (gone[key_q]) begin
          st_n = ST_UNATT;
        end else if (cls[!key_q] == TERM_RD && att_ok[!key_q] &&
                     cls[key_q] == TERM_RA) begin
          st_n  = ST_SNK_CBL;
          key_n = !key_q;
        end
      end
      ST_DBG, ST_AUD: begin
        if (gone[0] || gone[1]) st_n = ST_UNATT;
      end
      default: st_n = ST_UNATT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_UNATT;
      key_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      key_q <= key_n;
    end
  end

  logic sink_on;
  assign sink_on   = (st_q == ST_SNK) || (st_q == ST_SNK_CBL);
  assign vbus_en   = sink_on;
  assign vconn1_en = (st_q == ST_SNK_CBL) &&  key_q;
  assign vconn2_en = (st_q == ST_SNK_CBL) && !key_q;
  assign orient    = sink_on && key_q;
  assign dbg_acc   = (st_q == ST_DBG);
  assign aud_acc   = (st_q == ST_AUD);

  AST_VCONN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(vconn1_en && vconn2_en)) // R7
    else $error("both VCONN enables high");
  AST_VCONN_NEEDS_VBUS: assert property (@(posedge clk) disable iff (!rst_n)
    (vconn1_en || vconn2_en) |-> vbus_en) // R7
    else $error("VCONN without VBUS");
  AST_VCONN_TO_RA: assert property (@(posedge clk) disable iff (!rst_n)
    (vconn1_en |-> cls[0] != TERM_RD) and (vconn2_en |-> cls[1] != TERM_RD)) // R11
    else $error("VCONN driven toward the sink pin");
  AST_DROP_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vbus_en) |-> (!vconn1_en && !vconn2_en && !orient)) // R10
    else $error("VCONN outlived VBUS");
  AST_ORIENT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !vbus_en |-> !orient) // R12
    else $error("orientation flagged with no sink");
  AST_DBG_NO_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_acc |-> (!vbus_en && !aud_acc)) // R8
    else $error("debug accessory with power or audio");
  AST_AUD_NO_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    aud_acc |-> !vbus_en) // R9
    else $error("audio accessory with power");
endmodule

// File: tb/tcsrc_attach_test.sv
module tcsrc_attach_test;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    adv_sel = 2'd0;
  logic [2:0]    cc1_lo_rd = '0, cc1_lo_ra = '0, cc2_lo_rd = '0, cc2_lo_ra = '0;
  logic [CW-1:0] t_attach = 8'd5, t_detach = 8'd2;
  logic vbus_en, vconn1_en, vconn2_en, orient, dbg_acc, aud_acc;

  always #4 clk = ~clk;  // 125 MHz

  tcsrc_attach #(.CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .adv_sel(adv_sel),
    .cc1_lo_rd(cc1_lo_rd), .cc1_lo_ra(cc1_lo_ra),
    .cc2_lo_rd(cc2_lo_rd), .cc2_lo_ra(cc2_lo_ra),
    .t_attach(t_attach), .t_detach(t_detach),
    .vbus_en(vbus_en), .vconn1_en(vconn1_en), .vconn2_en(vconn2_en),
    .orient(orient), .dbg_acc(dbg_acc), .aud_acc(aud_acc)
  );

  // expected word: {vbus, vconn1, vconn2, orient, dbg, aud}
  localparam logic [5:0] E_OFF  = 6'b000000;
  localparam logic [5:0] E_SNK1 = 6'b100000;
  localparam logic [5:0] E_SNK2 = 6'b100100;
  localparam logic [5:0] E_SC2  = 6'b110100;
  localparam logic [5:0] E_DBG  = 6'b000010;
  localparam logic [5:0] E_AUD  = 6'b000001;

  int total = 0, bad = 0;
  bit done = 0;
  logic [5:0] exp_q [$];
  string      req_q [$];
  event       chk_ev;

  // monitor: pops expected items and compares against the ports
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        logic [5:0] e, a;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        a = {vbus_en, vconn1_en, vconn2_en, orient, dbg_acc, aud_acc};
        total++;
        if (a !== e) begin
          bad++;
          $display("FAIL %s: got %b expected %b at %0t", r, a, e, $time);
        end
      end
    end
  end

  task automatic expect_in(int n, logic [5:0] e, string r);
    repeat (n) @(posedge clk);
    @(negedge clk);
    exp_q.push_back(e);
    req_q.push_back(r);
    ->chk_ev;
    #1;
  endtask

  // term: 0 open, 1 Rd, 2 Ra (all three levels alike)
  task automatic set_pin(int p, int term);
    logic [2:0] rd, ra;
    rd = (term != 0) ? 3'b111 : 3'b000;
    ra = (term == 2) ? 3'b111 : 3'b000;
    if (p == 1) begin cc1_lo_rd = rd; cc1_lo_ra = ra; end
    else        begin cc2_lo_rd = rd; cc2_lo_ra = ra; end
  endtask

  task automatic go_idle();
    set_pin(1, 0);
    set_pin(2, 0);
    expect_in(20, E_OFF, "R10");
  endtask

  initial begin
    int ta, td;
    ta = 5; td = 2;
    repeat (3) @(negedge clk);
    expect_in(0, E_OFF, "R1");
    rst_n = 1'b1;
    expect_in(1, E_OFF, "R1");

    // sink on CC1, attach debounce edge
    set_pin(1, 1);
    expect_in(ta + 1, E_OFF, "R3");
    expect_in(1, E_SNK1, "R4");
    // other pin ignored while sink attached
    set_pin(2, 2);
    expect_in(10, E_SNK1, "R5");
    set_pin(2, 0);
    expect_in(10, E_SNK1, "R5");
    // detach on the Rd pin
    set_pin(1, 0);
    expect_in(td + 1, E_SNK1, "R5");
    expect_in(1, E_OFF, "R10");
    expect_in(10, E_OFF, "R10");

    // threshold selection: only the 3 A Rd comparator is low
    cc2_lo_rd = 3'b100;
    expect_in(20, E_OFF, "R2");
    adv_sel = 2'd2;
    expect_in(ta + 1, E_OFF, "R3");
    expect_in(1, E_SNK2, "R2");
    adv_sel = 2'd1;
    expect_in(td + 2, E_OFF, "R2");
    cc2_lo_rd = 3'b001;
    adv_sel = 2'd3;
    expect_in(ta + 2, E_SNK2, "R2");
    adv_sel = 2'd0;
    go_idle();

    // cable only, then sink arrives
    set_pin(1, 2);
    expect_in(ta + 2, E_OFF, "R6");
    expect_in(10, E_OFF, "R6");
    set_pin(2, 1);
    expect_in(ta + 1, E_OFF, "R6");
    expect_in(1, E_SC2, "R6");
    set_pin(1, 0);
    expect_in(10, E_SC2, "R7");
    set_pin(1, 2);
    expect_in(2, E_SC2, "R7");
    set_pin(2, 0);
    expect_in(td + 1, E_SC2, "R10");
    expect_in(1, E_OFF, "R10");
    expect_in(10, E_OFF, "R6");

    // removal and arrival mature together
    t_detach = 8'd5; td = 5;
    set_pin(1, 0);
    set_pin(2, 1);
    expect_in(ta + 2, E_OFF, "R11");
    expect_in(1, E_SNK2, "R11");
    set_pin(2, 0);
    expect_in(td + 2, E_OFF, "R10");
    t_detach = 8'd2; td = 2;
    go_idle();

    // debug accessory
    set_pin(1, 1);
    set_pin(2, 1);
    expect_in(ta + 2, E_DBG, "R8");
    set_pin(2, 0);
    expect_in(td + 1, E_DBG, "R8");
    expect_in(1, E_OFF, "R8");
    expect_in(10, E_SNK1, "R8");
    go_idle();

    // audio accessory
    set_pin(1, 2);
    set_pin(2, 2);
    expect_in(ta + 2, E_AUD, "R9");
    set_pin(1, 0);
    expect_in(td + 1, E_AUD, "R9");
    expect_in(1, E_OFF, "R9");
    go_idle();

    // glitch restarts the attach count
    set_pin(1, 1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    set_pin(1, 0);
    @(posedge clk);
    @(negedge clk);
    set_pin(1, 1);
    expect_in(ta + 1, E_OFF, "R3");
    expect_in(1, E_SNK1, "R3");
    go_idle();

    // reset in the middle of an attach
    set_pin(2, 1);
    expect_in(ta + 2, E_SNK2, "R4");
    rst_n = 1'b0;
    #1;
    exp_q.push_back(E_OFF); req_q.push_back("R1"); ->chk_ev; #1;
    expect_in(2, E_OFF, "R1");
    rst_n = 1'b1;
    expect_in(ta + 1, E_OFF, "R1");
    expect_in(1, E_SNK2, "R1");
    go_idle();

    done = 1;
    #1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule